// File: doc/BRIEF.md
# Burst-Capable Asynchronous Register Bus Slave

This block links an external microcontroller to an on-chip register file. The microcontroller drives its strobes without a clock. The block brings those strobes into the internal clock domain and turns each data-strobe low phase into a single read or write on the register file side. It then answers with an active-low acknowledge. An 8-bit bidirectional data bus carries the read data back to the master.

A rising address strobe (with chip select low) captures the 7-bit address and opens a burst. The first access of the burst goes to the captured address. Every later data-strobe low phase goes to the previous address plus one, and the address wraps at the top of the space. Lowering the address strobe closes the burst. While no burst is open, each access goes straight to the address on the pins.

The register file is expected to return read data one clock after the read enable, which is the usual behaviour of an inferred block RAM.

Top module: `regbus_burst_slave`

## Requirements
- R1: While reset is held and right after it, `bus_ack_n` is 1, `rf_rd_en` is 0 and `rf_wr_en` is 0.
- R2: The first access after the address strobe rises (chip select low) targets the address that was on `bus_a` when the strobe rose, even if the pins change afterwards.
- R3: Within an open burst, every later access targets the previous target plus one.
- R4: A burst address of 0x7F is followed by 0x00, for reads and for writes alike.
- R5: An access with `bus_rnw` = 1 is a read. It pulses `rf_rd_en` and then drives the register content (`rf_rdata`, one clock after the enable) onto `bus_d` while the acknowledge is low.
- R6: An access with `bus_rnw` = 0 is a write. It raises `rf_wr_en` for exactly one clock, with `rf_addr` set to the target and `rf_wdata` set to the value on `bus_d`.
- R7: `bus_ack_n` goes low on the fifth rising clock edge after `bus_ds_n` falls: two edges of synchronisation, one edge that issues the access, and two more edges.
- R8: `bus_ack_n` returns to 1 on the third rising clock edge after `bus_ds_n` rises, and `bus_d` is released at the same edge.
- R9: A falling address strobe closes the burst. Accesses made after it use the `bus_a` pins directly and do not increment.
- R10: While `bus_cs_n` is 1, data-strobe activity issues no register access, and the acknowledge stays high.
- R11: A new rising address strobe after a closed burst captures a fresh start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_as | input | 1 | Address strobe; rising edge captures the address, falling edge ends the burst |
| bus_ds_n | input | 1 | Data strobe, active low; each low phase is one access |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_a | input | 7 | Address pins |
| bus_d | inout | 8 | Bidirectional data bus |
| bus_ack_n | output | 1 | Data acknowledge, active low |
| rf_addr | output | 7 | Register file address |
| rf_rd_en | output | 1 | Register file read enable, one cycle |
| rf_wr_en | output | 1 | Register file write enable, one cycle |
| rf_wdata | output | 8 | Register file write data |
| rf_rdata | input | 8 | Register file read data, one cycle after `rf_rd_en` |

## Verification
The bench runs short three-access read bursts from start addresses spread over the whole space. These show whether the captured address or the live pins are used, and whether the step is exactly one. A full 128-access write burst that starts mid-space, followed by a read-back, separates correct wrapping from saturation or a missed location. Programmed accesses with fixed pins after the burst closes distinguish a real burst end from a latch that keeps counting. A strobe toggled with chip select high separates a gated access from one that leaks through. Every access also measures the acknowledge assertion and release times in clock edges.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/regbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
module regbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/regbus_addr_seq.sv
// Burst address sequencer: captures on address-strobe rise, steps per access.
module regbus_addr_seq #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          as_s,
  input  logic [AW-1:0] addr_s,
  input  logic          acc_go,
  output logic [AW-1:0] tgt_addr
);
  localparam logic [AW-1:0] STEP = {{(AW-1){1'b0}}, 1'b1};

  logic          as_prev;
  logic          first_q;
  logic          burst_q;
  logic [AW-1:0] cur_q;
  logic          as_rise;
  logic          as_fall;

  assign as_rise = !as_prev && as_s && !cs_n_s;
  assign as_fall = as_prev && !as_s;

  always_comb begin
    if (!burst_q)     tgt_addr = addr_s;
    else if (first_q) tgt_addr = cur_q;
    else              tgt_addr = cur_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      as_prev <= 1'b0;
      first_q <= 1'b0;
      burst_q <= 1'b0;
      cur_q   <= '0;
    end else begin
      as_prev <= as_s;
      if (as_rise) begin
        cur_q   <= addr_s;
        first_q <= 1'b1;
        burst_q <= 1'b1;
      end else if (as_fall) begin
        first_q <= 1'b0;
        burst_q <= 1'b0;
      end else if (acc_go && burst_q) begin
        cur_q   <= tgt_addr;
        first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regbus_access_ctrl.sv
// Turns synchronised data-strobe phases into register file accesses and
// generates the acknowledge and the bus drive enable.
module regbus_access_ctrl
  import regbus_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          ds_n_s,
  input  logic          rnw_s,
  input  logic [DW-1:0] wdata_s,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] rf_rdata,
  output logic          acc_go,
  output logic [AW-1:0] rf_addr,
  output logic          rf_rd_en,
  output logic          rf_wr_en,
  output logic [DW-1:0] rf_wdata,
  output logic [DW-1:0] dout,
  output logic          oe,
  output logic          ack_n
);
  localparam int STG_W = RD_LAT + 1;

  logic             ds_prev;
  logic             ds_rise;
  logic [STG_W-1:0] stg_q;
  acc_kind_e        kind_q;

  assign acc_go  = ds_prev && !ds_n_s && !cs_n_s;
  assign ds_rise = !ds_prev && ds_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_prev  <= 1'b1;
      stg_q    <= '0;
      kind_q   <= ACC_IDLE;
      rf_addr  <= '0;
      rf_rd_en <= 1'b0;
      rf_wr_en <= 1'b0;
      rf_wdata <= '0;
      dout     <= '0;
      oe       <= 1'b0;
      ack_n    <= 1'b1;
    end else begin
      ds_prev  <= ds_n_s;
      rf_rd_en <= 1'b0;
      rf_wr_en <= 1'b0;
      if (cs_n_s || ds_rise) begin
        stg_q  <= '0;
        kind_q <= ACC_IDLE;
        oe     <= 1'b0;
        ack_n  <= 1'b1;
      end else begin
        stg_q <= (stg_q << 1) | STG_W'(acc_go);
        if (acc_go) begin
          rf_addr <= tgt_addr;
          if (rnw_s) begin
            kind_q   <= ACC_READ;
            rf_rd_en <= 1'b1;
          end else begin
            kind_q   <= ACC_WRITE;
            rf_wr_en <= 1'b1;
            rf_wdata <= wdata_s;
          end
        end
        if (stg_q[RD_LAT]) begin
          ack_n <= 1'b0;
          if (kind_q == ACC_READ) begin
            dout <= rf_rdata;
            oe   <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/regbus_burst_slave.sv
module regbus_burst_slave #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_as,
  input  logic          bus_ds_n,
  input  logic          bus_rnw,
  input  logic [AW-1:0] bus_a,
  inout  wire  [DW-1:0] bus_d,
  output logic          bus_ack_n,
  output logic [AW-1:0] rf_addr,
  output logic          rf_rd_en,
  output logic          rf_wr_en,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata
);
  localparam int DAT_W = 1 + AW + DW;

  logic          cs_n_s;
  logic          as_s;
  logic          ds_n_s;
  logic          rnw_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] wdata_s;
  logic [AW-1:0] tgt_addr;
  logic          acc_go;
  logic [DW-1:0] dout;
  logic          bus_oe;

  regbus_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({bus_cs_n, bus_as, bus_ds_n}),
    .q({cs_n_s, as_s, ds_n_s})
  );

  regbus_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst(rst),
    .d({bus_rnw, bus_a, bus_d}),
    .q({rnw_s, addr_s, wdata_s})
  );

  regbus_addr_seq #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .as_s(as_s), .addr_s(addr_s),
    .acc_go(acc_go), .tgt_addr(tgt_addr)
  );

  regbus_access_ctrl #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_n_s(cs_n_s), .ds_n_s(ds_n_s), .rnw_s(rnw_s), .wdata_s(wdata_s),
    .tgt_addr(tgt_addr), .rf_rdata(rf_rdata),
    .acc_go(acc_go), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
    .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata),
    .dout(dout), .oe(bus_oe), .ack_n(bus_ack_n)
  );

  assign bus_d = bus_oe ? dout : {DW{1'bz}};
endmodule

// File: rtl/regbus_burst_slave_chk.sv
module regbus_burst_slave_chk #(
  parameter int RD_LAT = 1
) (
  input logic clk,
  input logic rst,
  input logic bus_ack_n,
  input logic rf_rd_en,
  input logic rf_wr_en,
  input logic cs_n_s,
  input logic bus_oe
);
  // R6: write enable never lasts longer than one clock
  p_one_cycle_we_r6: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> !rf_wr_en);

  // R5: read and write are never issued together
  p_rd_wr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(rf_rd_en && rf_wr_en));

  // R7: acknowledge falls a fixed distance after an issued access
  p_ack_after_access_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_n) |-> $past(rf_rd_en || rf_wr_en, RD_LAT + 1));

  // R10: deselected chip leaves acknowledge high and bus released
  p_cs_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (bus_ack_n && !bus_oe));

  // R5: bus is driven only while the acknowledge is low
  p_drive_with_ack_r5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !bus_ack_n);
endmodule

bind regbus_burst_slave regbus_burst_slave_chk #(.RD_LAT(RD_LAT)) u_chk (
  .clk(clk), .rst(rst), .bus_ack_n(bus_ack_n), .rf_rd_en(rf_rd_en),
  .rf_wr_en(rf_wr_en), .cs_n_s(cs_n_s), .bus_oe(bus_oe)
);

// File: tb/regbus_burst_slave_tb_top.sv
`timescale 1ns/1ps
module regbus_burst_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, as_i = 1'b0, ds_n = 1'b1, rnw = 1'b1;
  logic [6:0] a_pins = '0;
  logic       m_oe = 1'b0;
  logic [7:0] m_dat = '0;
  wire  [7:0] bus_d;
  logic       ack_n;
  logic [6:0] rf_addr;
  logic       rf_rd_en, rf_wr_en;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata = '0;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  int rd_cnt = 0, wr_cnt = 0;
  logic [6:0] last_ra = '0, last_wa = '0;
  logic [7:0] last_wd = '0;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign bus_d = m_oe ? m_dat : 8'bz;

  regbus_burst_slave dut_i (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_as(as_i), .bus_ds_n(ds_n),
    .bus_rnw(rnw), .bus_a(a_pins), .bus_d(bus_d), .bus_ack_n(ack_n),
    .rf_addr(rf_addr), .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // Register file model with one-cycle read latency
  always @(posedge clk) begin
    if (rf_wr_en) begin
      mem[rf_addr] <= rf_wdata;
      wr_cnt  <= wr_cnt + 1;
      last_wa <= rf_addr;
      last_wd <= rf_wdata;
    end
    if (rf_rd_en) begin
      rf_rdata <= mem[rf_addr];
      rd_cnt   <= rd_cnt + 1;
      last_ra  <= rf_addr;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic burst_open(input logic [6:0] a);
    @(negedge clk);
    cs_n = 1'b0;
    a_pins = a;
    @(negedge clk);
    as_i = 1'b1;
    repeat (4) @(negedge clk);
    a_pins = ~a;
  endtask

  task automatic burst_close();
    @(negedge clk);
    as_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // One data-strobe phase; returns read data and edge counts
  task automatic access(input logic is_rd, input logic [7:0] wd,
                        output logic [7:0] rd, output int t_ack, output int t_rel);
    @(negedge clk);
    rnw = is_rd;
    m_oe = !is_rd;
    m_dat = wd;
    ds_n = 1'b0;
    t_ack = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      t_ack++;
      @(negedge clk);
      if (!ack_n) break;
    end
    rd = bus_d;
    ds_n = 1'b1;
    t_rel = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      t_rel++;
      @(negedge clk);
      if (ack_n) break;
    end
    m_oe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_burst(input logic [6:0] s, input int n, input string req);
    logic [7:0] d;
    int ta, tr, c0;
    burst_open(s);
    for (int k = 0; k < n; k++) begin
      c0 = rd_cnt;
      access(1'b1, 8'h00, d, ta, tr);
      chk({req, " R3 read addr"}, int'(last_ra), int'(7'(s + 7'(k))));
      chk({req, " R5 read data"}, int'(d), int'(exp_mem[7'(s + 7'(k))]));
      chk("R5 one read enable", rd_cnt - c0, 1);
      chk("R7 ack delay", ta, 5);
      chk("R8 release delay", tr, 3);
    end
    burst_close();
  endtask

  task automatic wr_burst(input logic [6:0] s, input int n, input int seed);
    logic [7:0] d, wd;
    int ta, tr, c0;
    burst_open(s);
    for (int k = 0; k < n; k++) begin
      wd = 8'((k * 13 + seed) & 255);
      c0 = wr_cnt;
      access(1'b0, wd, d, ta, tr);
      exp_mem[7'(s + 7'(k))] = wd;
      chk("R6 one write cycle", wr_cnt - c0, 1);
      chk("R4 write addr", int'(last_wa), int'(7'(s + 7'(k))));
      chk("R6 write data", int'(last_wd), int'(wd));
      chk("R7 write ack delay", ta, 5);
    end
    burst_close();
  endtask

  initial begin
    logic [7:0] d;
    int ta, tr, c0, c1;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'((i * 7 + 3) & 255);
      exp_mem[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (4) @(negedge clk);
    chk("R1 ack in reset", int'(ack_n), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack after reset", int'(ack_n), 1);
    chk("R1 rd_en after reset", int'(rf_rd_en), 0);
    chk("R1 wr_en after reset", int'(rf_wr_en), 0);

    // R2/R3 basic read burst
    rd_burst(7'h10, 4, "R2");
    // R4/R6 write burst across the top, then read back
    wr_burst(7'h7D, 5, 144);
    rd_burst(7'h7E, 4, "R4");
    // Full-space write burst starting mid-range, then read sweep
    wr_burst(7'h40, 128, 5);
    for (int s = 0; s < 128; s += 9) rd_burst(7'(s), 3, "R2");

    // R9: after burst closed, pins used directly, no increment
    @(negedge clk);
    a_pins = 7'h33;
    access(1'b1, 8'h00, d, ta, tr);
    chk("R9 direct addr", int'(last_ra), 'h33);
    chk("R9 direct data", int'(d), int'(exp_mem[7'h33]));
    access(1'b1, 8'h00, d, ta, tr);
    chk("R9 no increment", int'(last_ra), 'h33);
    a_pins = 7'h34;
    access(1'b1, 8'h00, d, ta, tr);
    chk("R9 follows pins", int'(last_ra), 'h34);

    // R11: fresh burst re-captures
    burst_open(7'h05);
    access(1'b1, 8'h00, d, ta, tr);
    chk("R11 new start", int'(last_ra), 'h05);
    access(1'b1, 8'h00, d, ta, tr);
    chk("R11 next", int'(last_ra), 'h06);
    burst_close();

    // R10: deselected
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    c0 = rd_cnt;
    c1 = wr_cnt;
    rnw = 1'b0;
    ds_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 ack stays high", int'(ack_n), 1);
    ds_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 no read", rd_cnt - c0, 0);
    chk("R10 no write", wr_cnt - c1, 0);
    chk("R10 ack still high", int'(ack_n), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule